// File: doc/BRIEF.md
# Byte-Sequenced DMA Channel Register Bank

This block holds the per-channel address and count registers of a four-channel DMA controller. Each channel has a base address, a base count, a current address and a current count, all 16 bits wide. Software reaches them through an 8-bit I/O port interface, where every register takes exactly one port. A single low/high byte pointer, shared by all channels, decides whether an access reaches bits 7:0 or bits 15:8. Software must therefore issue two accesses to the same port in a row, low byte first, and it can reset the pointer with a dedicated clear port. The count is held as the number of transfers minus one, so 0x0000 means one transfer and 0xFFFF means 65536 transfers.

A transfer engine sits on the other side. It sees every channel's current address and current count as flat vectors. It gets a one-cycle load strobe whenever software writes a channel's register. It can step a channel, which increments the address and decrements the count, or reload a channel's current registers from its base registers. When a step takes the count from zero down to 0xFFFF, the block raises a terminal-count pulse. A master-clear port zeroes every register and the pointer.

Top module: `chreg_bank`

## Requirements
- R1: After synchronous reset, every current and base register is 0x0000, the byte pointer selects the low byte, and no load or terminal-count pulse is high.
- R2: Port offset 2n reaches channel n's address register and port offset 2n+1 reaches its count register, for n = 0..3.
- R3: A write to a register port stores the data byte into both the base and the current register of that channel. It goes into bits 7:0 when the pointer is low and into bits 15:8 when it is high. The other byte is left as it was.
- R4: The byte pointer is shared by all channels. It toggles after every read or write of any port at offsets 0..7, so accesses to different channels carry on one low/high sequence.
- R5: A write of any value to offset 12 sets the pointer to low. The next register access then reaches bits 7:0.
- R6: A write of any value to offset 13 zeroes all base and current registers of every channel, sets the pointer to low and clears the pulses.
- R7: A read of offset 2n or 2n+1 returns, on `io_rdata` in the same cycle, the byte of channel n's current address or current count that the pointer selects. The read changes no register.
- R8: A step of channel n adds one to its current address and subtracts one from its current count, modulo 2^16. A step at count 0x0000 leaves 0xFFFF and raises `tc_pulse[n]` for the following cycle.
- R9: A reload of channel n copies its base address and base count into its current registers. Reload takes priority over a step on the same channel.
- R10: In the cycle after a write to channel n's address or count port, `ld_pulse[n]` is high and every other load pulse is low.
- R11: Writes to offsets 8..11, 14 and 15 change no register and do not move the pointer.
- R12: When a software write to channel n coincides with a step or reload of channel n, the write is applied and the step or reload of that channel is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_wr | input | 1 | Port write strobe, one cycle per access |
| io_rd | input | 1 | Port read strobe, one cycle per access |
| io_addr | input | 4 | Port offset |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Read data byte, valid in the cycle of the read |
| step_vld | input | 1 | Engine steps the channel on `step_ch` |
| step_ch | input | 2 | Channel to step |
| reload | input | 4 | Per-channel reload of current from base |
| cur_addr | output | 64 | Current addresses, channel n in bits 16n+15:16n |
| cur_cnt | output | 64 | Current counts minus one, channel n in bits 16n+15:16n |
| ld_pulse | output | 4 | Per-channel register-written strobe |
| tc_pulse | output | 4 | Per-channel count-wrapped strobe |

## Verification
The hardest situation to set up from the ports is a pointer that is out of phase with the channel being accessed. This happens when an odd number of accesses to one channel leaves the pointer high, and the next access to a different channel then lands on that channel's high byte. The stimulus creates this on purpose with directed interleavings, and random stimulus keeps clear-pointer writes rare, so long runs drift through both phases. The count wrap is reached by stepping a channel whose count was loaded as 0x0000. The write-versus-step collision is driven on one channel in a single cycle.

// File: rtl/chreg_pkg.sv
package chreg_pkg;

    localparam int BYTE_W = 8;
    localparam int REG_W  = 16;

    typedef logic [REG_W-1:0]  reg16_t;
    typedef logic [BYTE_W-1:0] byte_t;

    // decoded port access for one cycle
    typedef struct packed {
        logic wr_reg;   // write to an address or count port
        logic rd_reg;   // read of an address or count port
        logic is_cnt;   // the port is a count port
        logic clr_ptr;  // pointer reset (clear port or master clear)
        logic mclr;     // master clear
    } acc_t;

    // replace one byte of a register, chosen by the pointer
    function automatic reg16_t put_byte(reg16_t r, logic hi, byte_t b);
        reg16_t v;
        v = r;
        if (hi) v[REG_W-1:BYTE_W] = b;
        else    v[BYTE_W-1:0]     = b;
        return v;
    endfunction

    // pick one byte of a register, chosen by the pointer
    function automatic byte_t get_byte(reg16_t r, logic hi);
        return hi ? r[REG_W-1:BYTE_W] : r[BYTE_W-1:0];
    endfunction

endpackage

// File: rtl/chreg_decode.sv
module chreg_decode
    import chreg_pkg::*;
#(
    parameter int NCH   = 4,
    parameter int CH_W  = $clog2(NCH),
    parameter int IOA_W = $clog2(2*NCH+6)
) (
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IOA_W-1:0] io_addr,
    output acc_t             acc,
    output logic [CH_W-1:0]  ch
);
    localparam logic [IOA_W-1:0] REG_END  = IOA_W'(2*NCH);
    localparam logic [IOA_W-1:0] CLR_OFF  = IOA_W'(2*NCH+4);
    localparam logic [IOA_W-1:0] MCLR_OFF = IOA_W'(2*NCH+5);

    logic is_reg;

    always_comb begin
        is_reg = (io_addr < REG_END);
        ch     = is_reg ? CH_W'(io_addr >> 1) : '0;

        acc         = '0;
        acc.is_cnt  = is_reg & io_addr[0];
        // a write wins when both strobes are raised together
        acc.wr_reg  = is_reg & io_wr;
        acc.rd_reg  = is_reg & io_rd & ~io_wr;
        acc.mclr    = io_wr & (io_addr == MCLR_OFF);
        acc.clr_ptr = io_wr & ((io_addr == CLR_OFF) | (io_addr == MCLR_OFF));
    end

endmodule

// File: rtl/chreg_ptr.sv
module chreg_ptr (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic touch,
    output logic ptr_hi
);
    always_ff @(posedge clk) begin
        if (rst || clear) ptr_hi <= 1'b0;
        else if (touch)   ptr_hi <= ~ptr_hi;
    end
endmodule

// File: rtl/chreg_channel.sv
module chreg_channel
    import chreg_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   mclr,
    input  logic   wr_addr,
    input  logic   wr_cnt,
    input  logic   hi,
    input  byte_t  wdata,
    input  logic   step,
    input  logic   reload,
    output reg16_t cur_addr,
    output reg16_t cur_cnt,
    output logic   ld_pulse,
    output logic   tc_pulse
);
    reg16_t base_addr;
    reg16_t base_cnt;
    logic   sw_hit;

    assign sw_hit = wr_addr | wr_cnt;

    always_ff @(posedge clk) begin
        if (rst || mclr) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            ld_pulse  <= 1'b0;
            tc_pulse  <= 1'b0;
        end else begin
            ld_pulse <= sw_hit;
            tc_pulse <= 1'b0;
            if (wr_addr) begin
                base_addr <= put_byte(base_addr, hi, wdata);
                cur_addr  <= put_byte(cur_addr,  hi, wdata);
            end
            if (wr_cnt) begin
                base_cnt <= put_byte(base_cnt, hi, wdata);
                cur_cnt  <= put_byte(cur_cnt,  hi, wdata);
            end
            if (!sw_hit) begin
                if (reload) begin
                    cur_addr <= base_addr;
                    cur_cnt  <= base_cnt;
                end else if (step) begin
                    cur_addr <= cur_addr + 1'b1;
                    cur_cnt  <= cur_cnt - 1'b1;
                    tc_pulse <= (cur_cnt == '0);
                end
            end
        end
    end
endmodule

// File: rtl/chreg_bank.sv
module chreg_bank
    import chreg_pkg::*;
#(
    parameter  int NCH   = 4,
    localparam int CH_W  = $clog2(NCH),
    localparam int IOA_W = $clog2(2*NCH+6),
    localparam int VEC_W = NCH*REG_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             io_wr,
    input  logic             io_rd,
    input  logic [IOA_W-1:0] io_addr,
    input  logic [7:0]       io_wdata,
    output logic [7:0]       io_rdata,
    input  logic             step_vld,
    input  logic [CH_W-1:0]  step_ch,
    input  logic [NCH-1:0]   reload,
    output logic [VEC_W-1:0] cur_addr,
    output logic [VEC_W-1:0] cur_cnt,
    output logic [NCH-1:0]   ld_pulse,
    output logic [NCH-1:0]   tc_pulse
);
    acc_t            acc;
    logic [CH_W-1:0] sel_ch;
    logic            ptr_hi;
    reg16_t          ca [NCH];
    reg16_t          cc [NCH];

    chreg_decode #(.NCH(NCH), .CH_W(CH_W), .IOA_W(IOA_W)) u_dec (
        .io_wr   (io_wr),
        .io_rd   (io_rd),
        .io_addr (io_addr),
        .acc     (acc),
        .ch      (sel_ch)
    );

    chreg_ptr u_ptr (
        .clk    (clk),
        .rst    (rst),
        .clear  (acc.clr_ptr),
        .touch  (acc.wr_reg | acc.rd_reg),
        .ptr_hi (ptr_hi)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit = (sel_ch == CH_W'(g));

        chreg_channel u_ch (
            .clk      (clk),
            .rst      (rst),
            .mclr     (acc.mclr),
            .wr_addr  (acc.wr_reg & hit & ~acc.is_cnt),
            .wr_cnt   (acc.wr_reg & hit &  acc.is_cnt),
            .hi       (ptr_hi),
            .wdata    (io_wdata),
            .step     (step_vld & (step_ch == CH_W'(g))),
            .reload   (reload[g]),
            .cur_addr (ca[g]),
            .cur_cnt  (cc[g]),
            .ld_pulse (ld_pulse[g]),
            .tc_pulse (tc_pulse[g])
        );

        assign cur_addr[g*REG_W +: REG_W] = ca[g];
        assign cur_cnt [g*REG_W +: REG_W] = cc[g];
    end

    always_comb begin
        io_rdata = '0;
        if (acc.rd_reg)
            io_rdata = get_byte(acc.is_cnt ? cc[sel_ch] : ca[sel_ch], ptr_hi);
    end

endmodule

// File: rtl/chreg_bank_chk.sv
module chreg_bank_chk
    import chreg_pkg::*;
#(
    parameter  int NCH   = 4,
    localparam int IOA_W = $clog2(2*NCH+6),
    localparam int VEC_W = NCH*REG_W
) (
    input logic             clk,
    input logic             rst,
    input logic             io_wr,
    input logic             io_rd,
    input logic [IOA_W-1:0] io_addr,
    input logic             step_vld,
    input logic [NCH-1:0]   reload,
    input logic             ptr_hi,
    input logic [VEC_W-1:0] cur_addr,
    input logic [VEC_W-1:0] cur_cnt,
    input logic [NCH-1:0]   ld_pulse,
    input logic [NCH-1:0]   tc_pulse
);
    localparam logic [IOA_W-1:0] REG_END  = IOA_W'(2*NCH);
    localparam logic [IOA_W-1:0] CLR_OFF  = IOA_W'(2*NCH+4);
    localparam logic [IOA_W-1:0] MCLR_OFF = IOA_W'(2*NCH+5);

    // R1
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (cur_addr == '0 && cur_cnt == '0 && !ptr_hi && ld_pulse == '0 && tc_pulse == '0));

    // R4
    p_ptr_toggle_r4: assert property (@(posedge clk) disable iff (rst)
        ((io_wr || io_rd) && io_addr < REG_END) |=> (ptr_hi != $past(ptr_hi)));

    // R5
    p_ptr_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == CLR_OFF) |=> !ptr_hi);

    // R6
    p_master_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (io_wr && io_addr == MCLR_OFF) |=> (cur_addr == '0 && cur_cnt == '0 && !ptr_hi));

    // R7
    p_read_keeps_r7: assert property (@(posedge clk) disable iff (rst)
        (io_rd && !io_wr && !step_vld && reload == '0) |=> ($stable(cur_addr) && $stable(cur_cnt)));

    // R10
    p_ld_single_r10: assert property (@(posedge clk) disable iff (rst) $onehot0(ld_pulse));

    // R11
    p_unused_ptr_r11: assert property (@(posedge clk) disable iff (rst)
        (io_wr && !io_rd && io_addr >= REG_END && io_addr != CLR_OFF && io_addr != MCLR_OFF)
        |=> $stable(ptr_hi));

    // R8
    p_tc_single_r8: assert property (@(posedge clk) disable iff (rst) $onehot0(tc_pulse));

    for (genvar g = 0; g < NCH; g++) begin : g_wrap
        // R8
        p_wrap_value_r8: assert property (@(posedge clk) disable iff (rst)
            tc_pulse[g] |-> (cur_cnt[g*REG_W +: REG_W] == {REG_W{1'b1}}));
    end

endmodule

bind chreg_bank chreg_bank_chk #(.NCH(NCH)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .io_wr    (io_wr),
    .io_rd    (io_rd),
    .io_addr  (io_addr),
    .step_vld (step_vld),
    .reload   (reload),
    .ptr_hi   (ptr_hi),
    .cur_addr (cur_addr),
    .cur_cnt  (cur_cnt),
    .ld_pulse (ld_pulse),
    .tc_pulse (tc_pulse)
);

// File: tb/chreg_bank_bench.sv
module chreg_bank_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        io_wr = 1'b0;
    logic        io_rd = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        step_vld = 1'b0;
    logic [1:0]  step_ch = '0;
    logic [3:0]  reload = '0;
    logic [63:0] cur_addr;
    logic [63:0] cur_cnt;
    logic [3:0]  ld_pulse;
    logic [3:0]  tc_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model
    logic [15:0] m_ca [4];
    logic [15:0] m_cc [4];
    logic [15:0] m_ba [4];
    logic [15:0] m_bc [4];
    bit          m_ptr;

    always #2.5 clk = ~clk;

    chreg_bank u_chreg_bank (
        .clk(clk), .rst(rst), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .step_vld(step_vld),
        .step_ch(step_ch), .reload(reload), .cur_addr(cur_addr),
        .cur_cnt(cur_cnt), .ld_pulse(ld_pulse), .tc_pulse(tc_pulse)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pack4(logic [15:0] v [4]);
        return {v[3], v[2], v[1], v[0]};
    endfunction

    function automatic logic [15:0] put_b(logic [15:0] r, bit hi, logic [7:0] b);
        return hi ? {b, r[7:0]} : {r[15:8], b};
    endfunction

    task automatic model_zero();
        for (int i = 0; i < 4; i++) begin
            m_ca[i] = '0; m_cc[i] = '0; m_ba[i] = '0; m_bc[i] = '0;
        end
        m_ptr = 1'b0;
    endtask

    // one cycle of stimulus, driven from a falling edge, checked at the next falling edge
    task automatic op(bit wr, bit rd, logic [3:0] a, logic [7:0] d,
                      bit st, logic [1:0] sch, logic [3:0] rl, string req);
        logic [3:0] exp_ld = '0;
        logic [3:0] exp_tc = '0;
        logic [7:0] exp_rd;
        int         wch = -1;
        logic [15:0] src;
        io_wr = wr; io_rd = rd; io_addr = a; io_wdata = d;
        step_vld = st; step_ch = sch; reload = rl;
        #1;
        if (rd && !wr && a < 8) begin
            src    = a[0] ? m_cc[a >> 1] : m_ca[a >> 1];
            exp_rd = m_ptr ? src[15:8] : src[7:0];
            chk(io_rdata == exp_rd, {req, " read data"}, 64'(io_rdata), 64'(exp_rd));
        end
        @(posedge clk);
        @(negedge clk);
        io_wr = 1'b0; io_rd = 1'b0; step_vld = 1'b0; reload = '0;
        // update model
        if (wr && a == 4'd13) begin
            model_zero();
        end else begin
            if (wr && a < 8) begin
                wch = int'(a >> 1);
                if (a[0]) begin
                    m_bc[wch] = put_b(m_bc[wch], m_ptr, d);
                    m_cc[wch] = put_b(m_cc[wch], m_ptr, d);
                end else begin
                    m_ba[wch] = put_b(m_ba[wch], m_ptr, d);
                    m_ca[wch] = put_b(m_ca[wch], m_ptr, d);
                end
                exp_ld[wch] = 1'b1;
                m_ptr = ~m_ptr;
            end else if (wr && a == 4'd12) begin
                m_ptr = 1'b0;
            end else if (!wr && rd && a < 8) begin
                m_ptr = ~m_ptr;
            end
            for (int i = 0; i < 4; i++) begin
                if (i != wch) begin
                    if (rl[i]) begin
                        m_ca[i] = m_ba[i];
                        m_cc[i] = m_bc[i];
                    end else if (st && int'(sch) == i) begin
                        exp_tc[i] = (m_cc[i] == 16'h0000);
                        m_ca[i] = m_ca[i] + 16'd1;
                        m_cc[i] = m_cc[i] - 16'd1;
                    end
                end
            end
        end
        chk(cur_addr == pack4(m_ca), {req, " cur_addr"}, cur_addr, pack4(m_ca));
        chk(cur_cnt  == pack4(m_cc), {req, " cur_cnt"},  cur_cnt,  pack4(m_cc));
        chk(ld_pulse == exp_ld, {req, " ld_pulse (R10)"}, 64'(ld_pulse), 64'(exp_ld));
        chk(tc_pulse == exp_tc, {req, " tc_pulse (R8)"},  64'(tc_pulse), 64'(exp_tc));
    endtask

    task automatic wr_port(logic [3:0] a, logic [7:0] d, string req);
        op(1'b1, 1'b0, a, d, 1'b0, 2'd0, 4'd0, req);
    endtask

    task automatic rd_port(logic [3:0] a, string req);
        op(1'b0, 1'b1, a, 8'h00, 1'b0, 2'd0, 4'd0, req);
    endtask

    task automatic step(logic [1:0] c, string req);
        op(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, c, 4'd0, req);
    endtask

    initial begin
        int seed_val;
        int r;
        seed_val = $urandom(32'h5eed_0c1a);
        model_zero();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state and a low-byte read of zero
        chk(cur_addr == '0 && cur_cnt == '0, "R1 registers", cur_addr | cur_cnt, 64'd0);
        chk(ld_pulse == '0 && tc_pulse == '0, "R1 pulses", 64'({ld_pulse, tc_pulse}), 64'd0);
        rd_port(4'd0, "R1");
        wr_port(4'd12, 8'h5A, "R5");
        // R2 / R3: channel 2 address, two bytes, low first
        wr_port(4'd4, 8'h34, "R2");
        wr_port(4'd4, 8'h12, "R3");
        chk(cur_addr[47:32] == 16'h1234, "R2 channel 2 address", 64'(cur_addr[47:32]), 64'h1234);
        // R8: count of one transfer, stepped to wrap
        wr_port(4'd3, 8'h00, "R3");
        wr_port(4'd3, 8'h00, "R3");
        step(2'd1, "R8");
        chk(cur_cnt[31:16] == 16'hFFFF, "R8 wrap", 64'(cur_cnt[31:16]), 64'hFFFF);
        // R4: interleaved channels without a pointer clear
        wr_port(4'd0, 8'hAA, "R4");
        wr_port(4'd7, 8'hBB, "R4");
        chk(cur_cnt[63:48] == 16'hBB00, "R4 high byte on channel 3", 64'(cur_cnt[63:48]), 64'hBB00);
        rd_port(4'd2, "R4");
        rd_port(4'd6, "R4");
        // R5: clear, then the next access is low
        rd_port(4'd1, "R5");
        wr_port(4'd12, 8'hFF, "R5");
        wr_port(4'd6, 8'hC3, "R5");
        wr_port(4'd12, 8'h00, "R5");
        rd_port(4'd6, "R5");
        // R11: writes to unused offsets
        wr_port(4'd9,  8'hFF, "R11");
        wr_port(4'd14, 8'hFF, "R11");
        wr_port(4'd8,  8'hFF, "R11");
        rd_port(4'd4, "R11");
        rd_port(4'd4, "R11");
        // R9: step then reload
        step(2'd2, "R9");
        step(2'd2, "R9");
        op(1'b0, 1'b0, 4'd0, 8'h00, 1'b1, 2'd2, 4'b0100, "R9");
        // R12: write and step/reload on the same channel together
        op(1'b1, 1'b0, 4'd5, 8'h77, 1'b1, 2'd2, 4'b0000, "R12");
        op(1'b1, 1'b0, 4'd5, 8'h66, 1'b0, 2'd0, 4'b0100, "R12");
        // R7: reads do not disturb registers
        rd_port(4'd5, "R7");
        rd_port(4'd5, "R7");
        // R6: master clear
        wr_port(4'd13, 8'h3C, "R6");
        rd_port(4'd0, "R6");
        // random mix
        for (int k = 0; k < 900; k++) begin
            r = $urandom_range(0, 99);
            if (r < 35)      wr_port(4'($urandom_range(0, 7)), 8'($urandom), "R3");
            else if (r < 60) rd_port(4'($urandom_range(0, 7)), "R7");
            else if (r < 64) wr_port(4'd12, 8'($urandom), "R5");
            else if (r < 84) step(2'($urandom_range(0, 3)), "R8");
            else if (r < 89) op(1'b0, 1'b0, 4'd0, 8'h00, 1'b0, 2'd0, 4'($urandom), "R9");
            else if (r < 93) op(1'b1, 1'b0, 4'($urandom_range(0, 7)), 8'($urandom),
                                1'b1, 2'($urandom_range(0, 3)), 4'($urandom), "R12");
            else if (r < 99) wr_port(4'($urandom_range(8, 11)), 8'($urandom), "R11");
            else             wr_port(4'd13, 8'($urandom), "R6");
        end
        wr_port(4'd13, 8'h00, "R6");
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule